// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM with one shared bidirectional data bus. The host offers one word at a time through a request/ready handshake carrying an address, write data and a direction flag. The controller then plays out the memory strobes (chip enable, output enable and write enable, all active low) so that every access meets the memory's access, pulse, setup and turnaround windows.

Every window is a whole number of clock cycles. Each count is worked out at elaboration time as the ceiling of a nanosecond parameter divided by the clock period, and is never less than one cycle. The data bus is split into an output word, an input word and a drive enable for an external tri-state pad. The controller turns its driver on only while the memory's outputs are off. When a write follows a read, it adds a turnaround gap so that the memory's output has time to float before the driver turns on.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset and whenever no transfer is in progress, ready is high, all three strobes are high and the drive enable is low. Ready is low in every other cycle, and a request is accepted only in a cycle where ready is high.
- R2: A read holds chip enable low, output enable low and write enable high, with the driver off, for AA = ceil(max(tAA, tOE) / T) cycles. One more cycle follows, so ready stays low for AA + 1 cycles.
- R3: After a read, the read data output holds the word the memory presented at the accepted address in the last output-enable cycle. It keeps that value until the next read completes.
- R4: During a write, output enable stays high. When write enable rises, the memory address and the output data equal the address and write data accepted with the request.
- R5: Write enable is low for exactly PW = ceil(max(tWP, tDW, tCW, tAW) / T) consecutive cycles in each write.
- R6: The driver is on for one setup cycle before write enable falls. It stays on through the cycle in which write enable rises, so it has been on for 1 + PW cycles when the rise occurs.
- R7: A write accepted when the previous transfer was a read is preceded by HZ = ceil(tHZ / T) turnaround cycles, with all strobes high and the driver off. A write that follows a write, or that is the first transfer after reset, has no turnaround.
- R8: In no cycle is the driver on while the memory is driving (chip enable low, output enable low, write enable high). Output enable and write enable are never low in the same cycle.
- R9: Once a request is accepted, changes on the host address, write data and direction inputs have no effect on that transfer.
- R10: A write keeps ready low for 1 + PW + RC cycles, plus HZ when R7 applies, where RC = max(1, ceil(tWC / T) - 1 - PW).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Transfer request, taken when ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_ready | output | 1 | Idle and able to accept a request |
| host_rdata | output | DATA_W | Word from the last completed read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Data toward the pad |
| mem_din | input | DATA_W | Data from the pad |
| mem_dout_en | output | 1 | Pad drive enable |

## Verification
The hardest case to reach is a read sampled one cycle too early. A memory that returns settled data at once would hide it. The bench memory model therefore returns the inverted word until output enable has been low for the full access count, so an early capture gives a wrong value. The turnaround gap and the bus-sharing rule are reached by alternating reads and writes and by checking the drive enable against the model's own drive condition at every cycle. After each acceptance, the bench scrambles the host inputs while the transfer runs.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RACC,
      ST_RCAP,
      ST_TURN,
      ST_WSET,
      ST_WPUL,
      ST_WREC
   } sramc_state_e;

   function automatic int unsigned win_cyc(input int unsigned ns, input int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] ld_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load)        cnt_q <= ld_val;
      else if (cnt_q != 0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
   import sramc_pkg::*;
#(
   parameter int unsigned CNT_W   = 2,
   parameter int unsigned AA_CYC  = 2,
   parameter int unsigned SET_CYC = 1,
   parameter int unsigned PUL_CYC = 1,
   parameter int unsigned REC_CYC = 1,
   parameter int unsigned HZ_CYC  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr,
   input  logic             zero,
   output sramc_state_e     state,
   output logic             load,
   output logic [CNT_W-1:0] ld_val,
   output logic             accept,
   output logic             cap_en,
   output logic             ready
);
   sramc_state_e state_q, nxt;
   logic         last_rd_q;

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         ST_IDLE: if (req) nxt = wr ? (last_rd_q ? ST_TURN : ST_WSET) : ST_RACC;
         ST_RACC: if (zero) nxt = ST_RCAP;
         ST_RCAP: if (zero) nxt = ST_IDLE;
         ST_TURN: if (zero) nxt = ST_WSET;
         ST_WSET: if (zero) nxt = ST_WPUL;
         ST_WPUL: if (zero) nxt = ST_WREC;
         ST_WREC: if (zero) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (nxt)
         ST_RACC: ld_val = CNT_W'(AA_CYC - 1);
         ST_TURN: ld_val = CNT_W'(HZ_CYC - 1);
         ST_WSET: ld_val = CNT_W'(SET_CYC - 1);
         ST_WPUL: ld_val = CNT_W'(PUL_CYC - 1);
         ST_WREC: ld_val = CNT_W'(REC_CYC - 1);
         default: ld_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         last_rd_q <= 1'b0;
      end else begin
         state_q <= nxt;
         if (state_q == ST_RCAP && zero)      last_rd_q <= 1'b1;
         else if (state_q == ST_WREC && zero) last_rd_q <= 1'b0;
      end
   end

   assign state  = state_q;
   assign load   = (nxt != state_q);
   assign ready  = (state_q == ST_IDLE);
   assign accept = ready && req;
   assign cap_en = (state_q == ST_RACC) && zero;
endmodule

// File: rtl/sramc_bus_io.sv
module sramc_bus_io
   import sramc_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sramc_state_e      state,
   input  logic              cap_en,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      mem_ce_n    = 1'b1;
      mem_oe_n    = 1'b1;
      mem_we_n    = 1'b1;
      mem_dout_en = 1'b0;
      unique case (state)
         ST_RACC: begin mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
         ST_RCAP: mem_ce_n = 1'b0;
         ST_WSET: begin mem_ce_n = 1'b0; mem_dout_en = 1'b1; end
         ST_WPUL: begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dout_en = 1'b1; end
         ST_WREC: mem_dout_en = 1'b1;
         default: ;
      endcase
   end

   assign mem_addr = addr_q;
   assign mem_dout = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (cap_en) rdata <= mem_din;
   end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sramc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 15,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned CLK_NS  = 10,
   parameter int unsigned T_AA_NS = 15,
   parameter int unsigned T_OE_NS = 7,
   parameter int unsigned T_WC_NS = 15,
   parameter int unsigned T_WP_NS = 9,
   parameter int unsigned T_CW_NS = 10,
   parameter int unsigned T_AW_NS = 10,
   parameter int unsigned T_DW_NS = 8,
   parameter int unsigned T_AS_NS = 0,
   parameter int unsigned T_HZ_NS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_dout_en
);
   localparam int unsigned AA_CYC  = win_cyc(umax(T_AA_NS, T_OE_NS), CLK_NS);
   localparam int unsigned SET_CYC = win_cyc(T_AS_NS, CLK_NS);
   localparam int unsigned PUL_CYC = win_cyc(umax(umax(T_WP_NS, T_DW_NS), umax(T_CW_NS, T_AW_NS)), CLK_NS);
   localparam int unsigned WC_CYC  = win_cyc(T_WC_NS, CLK_NS);
   localparam int unsigned REC_CYC = (WC_CYC > SET_CYC + PUL_CYC) ? WC_CYC - SET_CYC - PUL_CYC : 1;
   localparam int unsigned HZ_CYC  = win_cyc(T_HZ_NS, CLK_NS);
   localparam int unsigned MAX_CYC = umax(umax(AA_CYC, PUL_CYC), umax(umax(REC_CYC, HZ_CYC), SET_CYC));
   localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   initial begin
      assert (ADDR_W > 0 && DATA_W > 0) else $error("sram_cycle_ctrl: widths must be nonzero");
      assert (CLK_NS > 0) else $error("sram_cycle_ctrl: clock period must be nonzero");
   end

   sramc_state_e      state;
   logic              load, zero, accept, cap_en;
   logic [CNT_W-1:0]  ld_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= host_addr;
         wdata_q <= host_wdata;
      end
   end

   sramc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .ld_val (ld_val),
      .zero   (zero)
   );

   sramc_fsm #(
      .CNT_W   (CNT_W),
      .AA_CYC  (AA_CYC),
      .SET_CYC (SET_CYC),
      .PUL_CYC (PUL_CYC),
      .REC_CYC (REC_CYC),
      .HZ_CYC  (HZ_CYC)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (host_req),
      .wr     (host_wr),
      .zero   (zero),
      .state  (state),
      .load   (load),
      .ld_val (ld_val),
      .accept (accept),
      .cap_en (cap_en),
      .ready  (host_ready)
   );

   sramc_bus_io #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .cap_en      (cap_en),
      .addr_q      (addr_q),
      .wdata_q     (wdata_q),
      .mem_din     (mem_din),
      .mem_ce_n    (mem_ce_n),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n),
      .mem_addr    (mem_addr),
      .mem_dout    (mem_dout),
      .mem_dout_en (mem_dout_en),
      .rdata       (host_rdata)
   );
endmodule

// File: rtl/sramc_chk.sv
module sramc_chk
   import sramc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 15,
   parameter int unsigned CLK_NS  = 10,
   parameter int unsigned T_WP_NS = 9,
   parameter int unsigned T_CW_NS = 10,
   parameter int unsigned T_AW_NS = 10,
   parameter int unsigned T_DW_NS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic              dout_en
);
   localparam int unsigned PW = win_cyc(umax(umax(T_WP_NS, T_DW_NS), umax(T_CW_NS, T_AW_NS)), CLK_NS);

   int unsigned low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low_cnt <= 0;
      else if (!we_n) low_cnt <= low_cnt + 1;
      else            low_cnt <= 0;
   end

   // R1
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (ce_n && oe_n && we_n && !dout_en));
   // R8
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ce_n && !oe_n && we_n && dout_en));
   // R8
   oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));
   // R5
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (low_cnt == PW));
   // R6
   drv_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> $past(dout_en));
   // R6
   drv_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> dout_en);
   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || $rose(we_n)) |-> $stable(addr));
   // R7
   turn_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_en) |-> $past(oe_n));
endmodule

bind sram_cycle_ctrl sramc_chk #(
   .ADDR_W  (ADDR_W),
   .CLK_NS  (CLK_NS),
   .T_WP_NS (T_WP_NS),
   .T_CW_NS (T_CW_NS),
   .T_AW_NS (T_AW_NS),
   .T_DW_NS (T_DW_NS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ready   (host_ready),
   .ce_n    (mem_ce_n),
   .oe_n    (mem_oe_n),
   .we_n    (mem_we_n),
   .addr    (mem_addr),
   .dout_en (mem_dout_en)
);

// File: tb/sram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_bench;
   localparam int CLK_PERIOD = 5;
   localparam int AA  = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int PW  = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int WC  = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int RC  = (WC > 1 + PW) ? WC - 1 - PW : 1;
   localparam int HZ  = (4 + CLK_PERIOD - 1) / CLK_PERIOD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_wr = 1'b0;
   logic [14:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic        host_ready;
   logic [7:0]  host_rdata;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dout, mem_din;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2.0) clk = ~clk;

   sram_cycle_ctrl #(.CLK_NS(CLK_PERIOD)) u_sram_cycle_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
      .host_rdata(host_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_din(mem_din), .mem_dout_en(mem_dout_en)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // memory model: low byte indexes storage, high bits fold into the stored word
   logic [7:0]  mem [256];
   logic [7:0]  shadow [256];
   int          acc_cnt = 0, pul_cnt = 0, drv_cnt = 0;
   logic        p_we = 1'b1, p_ce = 1'b1;
   logic [14:0] p_addr = '0;
   logic [7:0]  p_dout = '0;
   logic [14:0] exp_waddr = '0;
   logic [7:0]  exp_wdata = '0;
   int          wr_seen = 0;
   wire         mdrive = !mem_ce_n && !mem_oe_n && mem_we_n;
   wire [7:0]   rd_word = mem[mem_addr[7:0]] ^ {1'b0, mem_addr[14:8]};
   assign mem_din = (mdrive && acc_cnt >= AA) ? rd_word : ~rd_word;

   initial for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
   end

   always @(negedge clk) if (rst_n) begin
      if (mdrive && mem_dout_en) chk(0, "R8 bus contention", 1, 0);
      if (!mem_oe_n && !mem_we_n) chk(0, "R8 oe and we low together", 1, 0);
      acc_cnt = mdrive ? acc_cnt + 1 : 0;
      if (mem_we_n && !p_we && !p_ce) begin
         wr_seen++;
         mem[p_addr[7:0]] = p_dout ^ {1'b0, p_addr[14:8]};
         chk(pul_cnt == PW, "R5 write pulse cycles", pul_cnt, PW);
         chk(drv_cnt == 1 + PW, "R6 drive cycles before we rise", drv_cnt, 1 + PW);
         chk(mem_dout_en, "R6 driver on at we rise", mem_dout_en, 1);
         chk(p_addr == exp_waddr, "R4 R9 write address", p_addr, exp_waddr);
         chk(p_dout == exp_wdata, "R4 R9 write data", p_dout, exp_wdata);
      end
      if (!mem_we_n && mem_oe_n == 1'b0) chk(0, "R4 oe low during write", 0, 1);
      pul_cnt = mem_we_n ? 0 : pul_cnt + 1;
      drv_cnt = mem_dout_en ? drv_cnt + 1 : 0;
      p_we = mem_we_n; p_ce = mem_ce_n; p_addr = mem_addr; p_dout = mem_dout;
   end

   bit last_rd = 0;

   task automatic xfer(input bit wr, input logic [14:0] a, input logic [7:0] d);
      int busy, exp_busy, seen0;
      logic [7:0] exp_rd;
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
      seen0 = wr_seen;
      if (wr) begin
         exp_waddr = a; exp_wdata = d;
         shadow[a[7:0]] = d ^ {1'b0, a[14:8]};
         exp_busy = 1 + PW + RC + (last_rd ? HZ : 0);
      end else begin
         exp_rd = shadow[a[7:0]] ^ {1'b0, a[14:8]};
         exp_busy = AA + 1;
      end
      @(negedge clk);
      // R9: scramble host inputs once the request is taken
      host_req = 1'b0; host_wr = ~wr; host_addr = a ^ 15'h5555; host_wdata = ~d;
      busy = 0;
      while (!host_ready && busy < 100) begin
         if (!mem_we_n || !mem_oe_n) chk(!mem_ce_n, "R2 R4 chip enable low during strobe", mem_ce_n, 0);
         if (!wr && !mem_oe_n) chk(mem_we_n && !mem_dout_en, "R2 read strobes", {mem_we_n, mem_dout_en}, 2);
         busy++;
         @(negedge clk);
      end
      if (wr) begin
         chk(busy == exp_busy, last_rd ? "R7 R10 write busy after read" : "R10 write busy", busy, exp_busy);
         chk(wr_seen == seen0 + 1, "R4 one write captured", wr_seen - seen0, 1);
      end else begin
         chk(busy == exp_busy, "R2 read busy cycles", busy, exp_busy);
         chk(host_rdata == exp_rd, "R3 R9 read data", host_rdata, exp_rd);
      end
      chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en, "R1 idle pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}, 14);
      last_rd = !wr;
   endtask

   initial begin
      logic [7:0] held;
      repeat (3) @(negedge clk);
      chk(host_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en, "R1 reset state",
          {host_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}, 30);
      rst_n = 1'b1;
      @(negedge clk);
      chk(host_ready, "R1 ready after reset", host_ready, 1);
      // first write after reset: no turnaround (R7)
      for (int i = 0; i < 48; i++) xfer(1'b1, 15'((i * 613 + 17) & 32'h7fff), 8'(i * 29 + 1));
      // read back, each followed by a write to force turnaround (R7)
      for (int i = 0; i < 48; i++) begin
         xfer(1'b0, 15'((i * 613 + 17) & 32'h7fff), 8'h00);
         xfer(1'b1, 15'((i * 1021 + 300) & 32'h7fff), 8'(i * 53 + 9));
      end
      // sweep of the low byte, aliased high bits, mostly unwritten words
      for (int i = 0; i < 256; i += 3) xfer(1'b0, 15'(i | ((i * 5) << 8)), 8'h00);
      // read data holds through writes (R3)
      xfer(1'b0, 15'h1234, 8'h00);
      held = host_rdata;
      xfer(1'b1, 15'h0042, 8'h99);
      xfer(1'b1, 15'h0043, 8'h98);
      chk(host_rdata == held, "R3 read data held across writes", host_rdata, held);
      xfer(1'b0, 15'h0042, 8'h00);
      xfer(1'b0, 15'h7F43, 8'h00);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule